// File: doc/BRIEF.md
# Multichannel Result Frame Packer

This block turns per-channel conversion results into output frames. Each channel supplies a 24-bit result, a power-enable bit and a valid flag. When the frame strobe arrives, the block takes a snapshot of the results and of the set of channels that belong in the frame. It then shifts the frame out MSB first, one bit per clock.

There are three modes. The first two share one serial line in time-division order. In the fixed-position mode every channel owns a slot, and absent channels send zeros. In the packed mode the slots of absent channels are removed, so later channels move forward. The third mode sends each channel on its own discrete line.

A channel takes part only when it is powered and its data is ready. A channel becomes ready at its first valid result after power-up. Powering a channel down clears its ready state. Channels that keep running are not affected by others powering up or down. A slot-count output tells the receiver how many slots the current frame carries.

Top module: `tdm_pack`

## Requirements
- R1: With mode_i = 2'b00 (fixed), tdm_o carries N slots of W bits in ascending channel order, each MSB first. A channel that is not included sends an all-zero slot. slot_cnt_o = N. Mode code 2'b11 behaves exactly like 2'b00.
- R2: With mode_i = 2'b01 (packed), tdm_o carries only the included channels, in ascending index with no gaps. slot_cnt_o equals the number of included channels and never exceeds N.
- R3: With mode_i = 2'b10 (discrete), dis_o[k] carries channel k's W-bit result MSB first, or zeros if the channel is not included. tdm_o stays low and slot_cnt_o = 1.
- R4: A channel is included at a strobe when pwr_i[k] is high and its ready state is set. Ready is set on any clock edge where valid_i[k] and pwr_i[k] are both high. It is cleared on the edge after pwr_i[k] is low. A channel that is powered but has not yet produced a valid result is excluded.
- R5: mode_i, data_i and the inclusion mask are captured on the clock edge where frame_i is high. The first bit is visible right after that edge. Changes to these inputs during a frame do not alter it.
- R6: After the last slot bit, tdm_o and every dis_o line stay low until the next strobe. dis_o is all zero in the two shared-line modes.
- R7: While reset is held, and until the first strobe, tdm_o, dis_o and slot_cnt_o are zero.
- R8: slot_cnt_o changes only on an edge where frame_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one serial bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame-start strobe |
| mode_i | input | 2 | 00 fixed, 01 packed, 10 discrete, 11 as fixed |
| pwr_i | input | N | Per-channel power enable |
| valid_i | input | N | Per-channel result-valid flag |
| data_i | input | N*W | Channel results, channel k at bits [k*W +: W] |
| tdm_o | output | 1 | Shared serial data line |
| dis_o | output | N | Per-channel discrete serial lines |
| slot_cnt_o | output | $clog2(N+1) | Slots in the current frame |

## Verification
The first frame bit and the new slot count appear one register after the strobe edge. Bit j therefore appears j cycles after that. The bench raises frame_i at a falling edge and reads slot_cnt_o and bit 0 at the next falling edge. After that it reads one bit at each falling edge, for eight bits past the longest frame, so the low tail is covered too. A change to valid_i takes effect on the next edge. For that reason the bench leaves one idle cycle between the power/valid update and the strobe, and its own ready model follows the same rule.

// File: rtl/tdm_pack_pkg.sv
package tdm_pack_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED = 2'b00,
    MODE_DYN   = 2'b01,
    MODE_DISC  = 2'b10,
    MODE_ALT   = 2'b11
  } mode_e;
endpackage

// File: rtl/tdm_ready_track.sv
module tdm_ready_track #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pwr_i,
  input  logic [N-1:0] valid_i,
  output logic [N-1:0] ready_o
);
  for (genvar k = 0; k < N; k++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ready_o[k] <= 1'b0;
      else         ready_o[k] <= pwr_i[k] & (ready_o[k] | valid_i[k]);
    end
  end
endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map
  import tdm_pack_pkg::*;
#(
  parameter int N  = 4,
  parameter int W  = 24,
  parameter int CW = $clog2(N+1)
) (
  input  mode_e          mode_i,
  input  logic [N-1:0]   incl_i,
  input  logic [N*W-1:0] data_i,
  output logic [N*W-1:0] slots_o,
  output logic [CW-1:0]  count_o
);
  int idx;
  always_comb begin
    slots_o = '0;
    idx     = 0;
    for (int k = 0; k < N; k++) begin
      if (mode_i == MODE_DYN) begin
        if (incl_i[k]) begin
          slots_o[idx*W +: W] = data_i[k*W +: W];
          idx = idx + 1;
        end
      end else if (incl_i[k]) begin
        slots_o[k*W +: W] = data_i[k*W +: W];
      end
    end
    case (mode_i)
      MODE_DYN:  count_o = CW'(idx);
      MODE_DISC: count_o = CW'(1);
      default:   count_o = CW'(N);
    endcase
  end
endmodule

// File: rtl/tdm_slot_shift.sv
module tdm_slot_shift #(
  parameter int N = 4,
  parameter int W = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           disc_i,   // per-lane shifting, no chaining
  input  logic [N*W-1:0] slots_i,
  output logic [N-1:0]   lane_o
);
  logic [N-1:0][W-1:0] sr_q;

  for (genvar j = 0; j < N; j++) begin : g_slot
    logic fill;
    if (j == N-1) begin : g_last
      assign fill = 1'b0;
    end else begin : g_chain
      assign fill = disc_i ? 1'b0 : sr_q[j+1][W-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sr_q[j] <= '0;
      else if (load_i) sr_q[j] <= slots_i[j*W +: W];
      else             sr_q[j] <= {sr_q[j][W-2:0], fill};
    end
    assign lane_o[j] = sr_q[j][W-1];
  end
endmodule

// File: rtl/tdm_pack.sv
module tdm_pack
  import tdm_pack_pkg::*;
#(
  parameter int N  = 4,
  parameter int W  = 24,
  localparam int CW = $clog2(N+1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           frame_i,
  input  logic [1:0]     mode_i,
  input  logic [N-1:0]   pwr_i,
  input  logic [N-1:0]   valid_i,
  input  logic [N*W-1:0] data_i,
  output logic           tdm_o,
  output logic [N-1:0]   dis_o,
  output logic [CW-1:0]  slot_cnt_o
);
  logic [N-1:0]   ready;
  logic [N-1:0]   incl;
  logic [N*W-1:0] slots;
  logic [CW-1:0]  cnt_d;
  logic [N-1:0]   lanes;
  mode_e          mode_in;
  mode_e          mode_q;

  assign mode_in = mode_e'(mode_i);
  assign incl    = ready & pwr_i;

  tdm_ready_track #(.N(N)) u_ready (
    .clk_i, .rst_ni, .pwr_i, .valid_i, .ready_o(ready)
  );

  tdm_slot_map #(.N(N), .W(W), .CW(CW)) u_map (
    .mode_i(mode_in), .incl_i(incl), .data_i,
    .slots_o(slots), .count_o(cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_FIXED;
      slot_cnt_o <= '0;
    end else if (frame_i) begin
      mode_q     <= mode_in;
      slot_cnt_o <= cnt_d;
    end
  end

  tdm_slot_shift #(.N(N), .W(W)) u_shift (
    .clk_i, .rst_ni, .load_i(frame_i),
    .disc_i(mode_q == MODE_DISC),
    .slots_i(slots), .lane_o(lanes)
  );

  assign tdm_o = (mode_q != MODE_DISC) & lanes[0];
  assign dis_o = (mode_q == MODE_DISC) ? lanes : '0;
endmodule

// File: rtl/tdm_pack_chk.sv
module tdm_pack_chk #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_i,
  input logic [1:0]    mode_i,
  input logic [N-1:0]  pwr_i,
  input logic          tdm_o,
  input logic [N-1:0]  dis_o,
  input logic [CW-1:0] slot_cnt_o,
  input logic [1:0]    mode_q,
  input logic [N-1:0]  ready
);
  // R3
  tdm_quiet_disc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b10) |-> !tdm_o);
  // R6
  dis_quiet_tdm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != 2'b10) |-> (dis_o == '0));
  // R8
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(slot_cnt_o));
  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_cnt_o <= CW'(N));
  // R4
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i != '1) |=> ((ready & ~$past(pwr_i)) == '0));
  // R3
  disc_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mode_i == 2'b10) |=> (slot_cnt_o == CW'(1)));
endmodule

bind tdm_pack tdm_pack_chk #(.N(N), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .mode_i(mode_i),
  .pwr_i(pwr_i), .tdm_o(tdm_o), .dis_o(dis_o), .slot_cnt_o(slot_cnt_o),
  .mode_q(mode_q), .ready(ready)
);

// File: tb/sim_tdm_pack.sv
`timescale 1ns/1ps
module sim_tdm_pack;
  localparam int N  = 4;
  localparam int W  = 24;
  localparam int CW = $clog2(N+1);
  localparam int L  = N*W + 8;
  localparam int NV = 10;
  // {mode, pwr, valid}
  localparam logic [9:0] VEC [NV] = '{
    {2'b00, 4'b1111, 4'b1111},
    {2'b01, 4'b1111, 4'b0000},
    {2'b01, 4'b1011, 4'b0000},
    {2'b00, 4'b1011, 4'b0000},
    {2'b10, 4'b1011, 4'b0000},
    {2'b01, 4'b1111, 4'b0000},
    {2'b01, 4'b1111, 4'b0100},
    {2'b01, 4'b0000, 4'b0000},
    {2'b11, 4'b0101, 4'b0101},
    {2'b10, 4'b1111, 4'b0000}
  };

  logic           clk = 0;
  logic           rst_n = 0;
  logic           frame = 0;
  logic [1:0]     mode = 0;
  logic [N-1:0]   pwr = 0;
  logic [N-1:0]   valid = 0;
  logic [N*W-1:0] data = 0;
  logic           tdm;
  logic [N-1:0]   dis;
  logic [CW-1:0]  cnt;
  logic [N-1:0]   ready_m = 0;
  int             errors = 0;
  int             checks = 0;

  always #2.5 clk = ~clk;

  tdm_pack #(.N(N), .W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .mode_i(mode),
    .pwr_i(pwr), .valid_i(valid), .data_i(data),
    .tdm_o(tdm), .dis_o(dis), .slot_cnt_o(cnt)
  );

  function automatic logic [W-1:0] dval(int vi, int k);
    logic [31:0] t;
    t = 32'h9E3779B9 * 32'(vi*8 + k + 1);
    return t[W-1:0] | {1'b1, {(W-1){1'b0}}};
  endfunction

  task automatic chk(string req, logic [L-1:0] act, logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(int vi, logic [1:0] md, logic [N-1:0] pw,
                           logic [N-1:0] vl, bit disturb);
    logic [L-1:0] exp_t, cap_t;
    logic [L-1:0] exp_d [N];
    logic [L-1:0] cap_d [N];
    logic [CW-1:0] exp_c;
    int j;
    @(negedge clk); pwr = pw; valid = vl; ready_m = pw & (ready_m | vl);
    @(negedge clk); valid = '0;
    for (int k = 0; k < N; k++) data[k*W +: W] = dval(vi, k);
    mode = md; frame = 1;
    exp_t = '0; j = 0;
    for (int k = 0; k < N; k++) exp_d[k] = '0;
    for (int k = 0; k < N; k++) begin
      if (md == 2'b01) begin
        if (ready_m[k]) begin exp_t[L-1-j*W -: W] = dval(vi, k); j++; end
      end else if (md == 2'b10) begin
        if (ready_m[k]) exp_d[k][L-1 -: W] = dval(vi, k);
      end else if (ready_m[k]) begin
        exp_t[L-1-k*W -: W] = dval(vi, k);
      end
    end
    exp_c = (md == 2'b01) ? CW'($countones(ready_m)) :
            (md == 2'b10) ? CW'(1) : CW'(N);
    @(negedge clk); frame = 0;
    chk(md == 2'b01 ? "R2 count" : md == 2'b10 ? "R3 count" : "R1 count",
        L'(cnt), L'(exp_c));
    for (int b = 0; b < L; b++) begin
      if (b > 0) @(negedge clk);
      if (disturb && b == 10) begin pwr[0] = 1'b0; data = ~data; end
      cap_t[L-1-b] = tdm;
      for (int k = 0; k < N; k++) cap_d[k][L-1-b] = dis[k];
    end
    ready_m = ready_m & pwr;
    // R6 covered by the zero tail and idle lines
    chk(disturb ? "R5 tdm" : md == 2'b01 ? "R2 tdm" :
        md == 2'b10 ? "R3 tdm" : "R1 tdm", cap_t, exp_t);
    for (int k = 0; k < N; k++)
      chk(md == 2'b10 ? "R3 dis" : "R6 dis", cap_d[k], exp_d[k]);
  endtask

  initial begin
    #20;
    // R7 during reset
    chk("R7 reset", L'({tdm, dis, cnt}), '0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk("R7 idle", L'({tdm, dis, cnt}), '0);
    for (int v = 0; v < NV; v++)
      run_frame(v, VEC[v][9:8], VEC[v][7:4], VEC[v][3:0], 1'b0);
    // R5 mid-frame changes
    run_frame(20, 2'b01, 4'b1111, 4'b1111, 1'b1);
    // R4 ch0 dropped mid-frame is now cleared
    run_frame(21, 2'b01, 4'b0111, 4'b0000, 1'b0);
    // R4 re-powered ch0 stays zero in fixed mode until valid
    run_frame(22, 2'b00, 4'b1111, 4'b0000, 1'b0);
    // R8 count holds without strobe
    begin
      logic [CW-1:0] c0;
      c0 = cnt;
      mode = 2'b01; pwr = 4'b0000;
      repeat (5) @(negedge clk);
      chk("R8 hold", L'(cnt), L'(c0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule